// File: doc/BRIEF.md
# Parallel Quadratic-Permutation Interleaver Address Generator

This block feeds interleaved addresses to a bank of parallel turbo sub-decoders. The interleaver is the quadratic permutation f(i) = (f1*i + f2*i*i) mod K. A code block of length K is cut into P equal segments of length M = K/P. Sub-decoder p walks the positions i = p*M + j for j = 0..M-1. For each position it is told where f(i) lives: a segment (bank) index, which steers the crossbar between decoders and memory banks, and an offset inside that segment.

No address table is stored. A short setup phase follows a start request. It finds M with a serial divider and splits the recursion increments into segment and offset parts. It then walks the recursion once to capture each lane's starting state. After setup the block emits one complete set of P addresses per clock. The offset is a single value shared by every lane, and the segment indices are updated lane by lane with additions that need one conditional subtraction each. P may be any divisor of K up to the lane count of the build, including values that are not powers of two.

Top module: `qpp_par_addr_gen`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_done and busy are 0, and out_offset and every out_blk field read 0.
- R2: After a start is accepted, out_valid is high for exactly M = K/P consecutive cycles. out_done is high for one cycle, in the cycle after the last valid one, with out_valid low in that cycle.
- R3: In the j-th valid cycle (j counts from 0), the field for lane p < P, out_blk[p*QW +: QW], equals f(p*M + j) / M, where f(i) = (f1*i + f2*i*i) mod K.
- R4: In the j-th valid cycle, out_offset equals f(p*M + j) mod M, and this value is the same for every active lane. It is 0 in the first valid cycle.
- R5: The fields for lanes p >= P read 0 during every valid cycle.
- R6: Any P from 1 to P_MAX that divides K is accepted, including P = 1 (M = K), P = K (M = 1) and P that is not a power of two.
- R7: When (f1, f2) is a permutation polynomial for K, the P active segment indices in each valid cycle are distinct and cover 0..P-1.
- R8: A start pulse, and any change of cfg_len, cfg_f1, cfg_f2 or cfg_par, while busy is high has no effect. The run in progress keeps its addresses and its length.
- R9: busy is high from the cycle after an accepted start through the last valid cycle, and low in the out_done cycle.
- R10: Block lengths up to 6144 are supported, provided cfg_f1 < K and cfg_f2 < K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only while busy is low |
| cfg_len | input | AW | Block length K |
| cfg_f1 | input | AW | Linear coefficient, less than K |
| cfg_f2 | input | AW | Quadratic coefficient, less than K |
| cfg_par | input | PW | Number of active lanes P, a divisor of K |
| busy | output | 1 | Setup or run in progress |
| out_valid | output | 1 | An address set is presented |
| out_offset | output | AW | Offset inside the segment, shared by all lanes |
| out_blk | output | P_MAX*QW | Segment index per lane, lane p at bits [p*QW +: QW] |
| out_done | output | 1 | One-cycle pulse after the last address set |

## Verification
Published permutation pairs for several block lengths are run with P set to values such as 3, 5, 6 and 8. These runs separate a correct segment/offset split from one that only gets the full address right, and they expose lanes that collide on a bank. Random lengths built as P times M with random coefficients mostly do not form permutations. They exercise the carry and wrap paths of the split recursion across many moduli, and degenerate shapes such as M = 1 and P = 1 test the setup walk at its edges. The longest length is run once, and a run with a second start and changed configuration injected halfway shows whether the latched configuration is held.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_DIV_LEN  = 3'd1,
      ST_DIV_STEP = 3'd2,
      ST_DIV_INC  = 3'd3,
      ST_WALK     = 3'd4,
      ST_RUN      = 3'd5
   } qpp_state_e;
endpackage

// File: rtl/qpp_mod_add.sv
// (a + b + cin) mod m for a, b < m, with one conditional subtraction.
module qpp_mod_add #(
   parameter int W = 13
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic [W-1:0] m,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] raw;
   logic [W:0] red;

   always_comb begin
      raw  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      red  = raw - {1'b0, m};
      cout = (raw >= {1'b0, m});
      sum  = cout ? red[W-1:0] : raw[W-1:0];
   end
endmodule

// File: rtl/qpp_serial_div.sv
// Restoring divider, one quotient bit per cycle, W cycles per division.
module qpp_serial_div #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic         done
);
   localparam int CW = $clog2(W + 1);

   logic [W:0]    acc;
   logic [W-1:0]  qsh;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    shifted;
   logic [W:0]    trial;
   logic          fits;

   always_comb begin
      shifted = {acc[W-1:0], qsh[W-1]};
      trial   = shifted - {1'b0, den};
      fits    = (shifted >= {1'b0, den});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         qsh  <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            acc <= '0;
            qsh <= num;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            acc <= fits ? trial : shifted;
            qsh <= {qsh[W-2:0], fits};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quo = qsh;
   assign rem = acc[W-1:0];
endmodule

// File: rtl/qpp_lane.sv
// Segment-index state of one lane: position q and increment g, both mod P.
module qpp_lane #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [PW-1:0] ld_q,
   input  logic [PW-1:0] ld_g,
   input  logic          adv,
   input  logic          cr,
   input  logic          cg,
   input  logic [PW-1:0] tq,
   input  logic [PW-1:0] modp,
   output logic [PW-1:0] q,
   output logic [PW-1:0] g
);
   logic [PW-1:0] q_nxt;
   logic [PW-1:0] g_nxt;
   logic          q_wrap;
   logic          g_wrap;

   qpp_mod_add #(.W(PW)) u_qadd (
      .a(q), .b(g), .cin(cr), .m(modp), .sum(q_nxt), .cout(q_wrap)
   );
   qpp_mod_add #(.W(PW)) u_gadd (
      .a(g), .b(tq), .cin(cg), .m(modp), .sum(g_nxt), .cout(g_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
         g <= '0;
      end else if (clr) begin
         q <= '0;
         g <= '0;
      end else if (load) begin
         q <= ld_q;
         g <= ld_g;
      end else if (adv) begin
         q <= q_nxt;
         g <= g_nxt;
      end
   end
endmodule

// File: rtl/qpp_par_addr_gen.sv
module qpp_par_addr_gen #(
   parameter int P_MAX = 8,
   parameter int AW    = 13,
   localparam int QW   = $clog2(P_MAX),
   localparam int PW   = $clog2(P_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [AW-1:0]       cfg_len,
   input  logic [AW-1:0]       cfg_f1,
   input  logic [AW-1:0]       cfg_f2,
   input  logic [PW-1:0]       cfg_par,
   output logic                busy,
   output logic                out_valid,
   output logic [AW-1:0]       out_offset,
   output logic [P_MAX*QW-1:0] out_blk,
   output logic                out_done
);
   import qpp_pkg::*;

   if (P_MAX < 2) begin : g_bad_lanes
      $error("qpp_par_addr_gen: P_MAX must be at least 2");
   end
   if (AW < 4) begin : g_bad_width
      $error("qpp_par_addr_gen: AW must be at least 4");
   end
   if (PW > AW) begin : g_bad_ratio
      $error("qpp_par_addr_gen: lane count too large for address width");
   end

   qpp_state_e    st;
   logic [AW-1:0] k_r, f1_r, f2_r, m_r, tr_r, r_r, gr_r, cnt_j;
   logic [PW-1:0] p_r, tq_r, cnt_p;
   logic          go_r, done_r;

   logic          accept;
   logic          div_done;
   logic [AW-1:0] div_num, div_den, div_quo, div_rem;
   logic [AW-1:0] g0_val, t0_val;
   logic          g0_unused, t0_unused;
   logic [AW-1:0] r_nxt, gr_nxt;
   logic          r_carry, gr_carry;
   logic          walk_last, walk_step, walk_cap, run_step, run_last;
   logic [PW-1:0] walk_q, walk_g;
   logic [PW-1:0] lane_q [P_MAX];
   logic [PW-1:0] lane_g [P_MAX];

   assign accept    = start && (st == ST_IDLE);
   assign walk_cap  = (st == ST_WALK) && (cnt_j == '0);
   assign walk_last = walk_cap && (cnt_p == p_r - 1'b1);
   assign walk_step = (st == ST_WALK) && !walk_last;
   assign run_step  = (st == ST_RUN);
   assign run_last  = run_step && (cnt_j == m_r - 1'b1);

   // first increment f1 + f2 and the increment step 2*f2, both mod K
   qpp_mod_add #(.W(AW)) u_g0 (
      .a(f1_r), .b(f2_r), .cin(1'b0), .m(k_r), .sum(g0_val), .cout(g0_unused)
   );
   qpp_mod_add #(.W(AW)) u_t0 (
      .a(f2_r), .b(f2_r), .cin(1'b0), .m(k_r), .sum(t0_val), .cout(t0_unused)
   );

   always_comb begin
      div_num = k_r;
      div_den = {{(AW-PW){1'b0}}, p_r};
      case (st)
         ST_DIV_STEP: begin div_num = g0_val; div_den = m_r; end
         ST_DIV_INC:  begin div_num = t0_val; div_den = m_r; end
         default:     begin div_num = k_r; div_den = {{(AW-PW){1'b0}}, p_r}; end
      endcase
   end

   qpp_serial_div #(.W(AW)) u_div (
      .clk(clk), .rst_n(rst_n), .go(go_r), .num(div_num), .den(div_den),
      .quo(div_quo), .rem(div_rem), .done(div_done)
   );

   // shared offset recursion, mod M
   qpp_mod_add #(.W(AW)) u_radd (
      .a(r_r), .b(gr_r), .cin(1'b0), .m(m_r), .sum(r_nxt), .cout(r_carry)
   );
   qpp_mod_add #(.W(AW)) u_gradd (
      .a(gr_r), .b(tr_r), .cin(1'b0), .m(m_r), .sum(gr_nxt), .cout(gr_carry)
   );

   // walker lane: steps through i = 0 .. (P-1)*M during setup
   qpp_lane #(.PW(PW)) u_walk (
      .clk(clk), .rst_n(rst_n), .clr(accept),
      .load((st == ST_DIV_STEP) && div_done),
      .ld_q('0), .ld_g(div_quo[PW-1:0]),
      .adv(walk_step), .cr(r_carry), .cg(gr_carry),
      .tq(tq_r), .modp(p_r), .q(walk_q), .g(walk_g)
   );

   for (genvar p = 0; p < P_MAX; p++) begin : g_lane
      logic cap_here, adv_here;
      assign cap_here = walk_cap && (cnt_p == PW'(p));
      assign adv_here = run_step && (PW'(p) < p_r);
      qpp_lane #(.PW(PW)) u_lane (
         .clk(clk), .rst_n(rst_n), .clr(accept),
         .load(cap_here), .ld_q(walk_q), .ld_g(walk_g),
         .adv(adv_here), .cr(r_carry), .cg(gr_carry),
         .tq(tq_r), .modp(p_r), .q(lane_q[p]), .g(lane_g[p])
      );
      assign out_blk[p*QW +: QW] = lane_q[p][QW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         k_r    <= '0;
         f1_r   <= '0;
         f2_r   <= '0;
         p_r    <= '0;
         m_r    <= '0;
         tq_r   <= '0;
         tr_r   <= '0;
         r_r    <= '0;
         gr_r   <= '0;
         cnt_j  <= '0;
         cnt_p  <= '0;
         go_r   <= 1'b0;
         done_r <= 1'b0;
      end else begin
         go_r   <= 1'b0;
         done_r <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               k_r   <= cfg_len;
               f1_r  <= cfg_f1;
               f2_r  <= cfg_f2;
               p_r   <= cfg_par;
               r_r   <= '0;
               gr_r  <= '0;
               go_r  <= 1'b1;
               st    <= ST_DIV_LEN;
            end
            ST_DIV_LEN: if (div_done) begin
               m_r  <= div_quo;
               go_r <= 1'b1;
               st   <= ST_DIV_STEP;
            end
            ST_DIV_STEP: if (div_done) begin
               gr_r <= div_rem;
               r_r  <= '0;
               go_r <= 1'b1;
               st   <= ST_DIV_INC;
            end
            ST_DIV_INC: if (div_done) begin
               tq_r  <= div_quo[PW-1:0];
               tr_r  <= div_rem;
               cnt_j <= '0;
               cnt_p <= '0;
               st    <= ST_WALK;
            end
            ST_WALK: begin
               if (walk_last) begin
                  cnt_j <= '0;
                  st    <= ST_RUN;
               end else begin
                  r_r  <= r_nxt;
                  gr_r <= gr_nxt;
                  if (cnt_j == m_r - 1'b1) begin
                     cnt_j <= '0;
                     cnt_p <= cnt_p + 1'b1;
                  end else begin
                     cnt_j <= cnt_j + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               r_r  <= r_nxt;
               gr_r <= gr_nxt;
               if (run_last) begin
                  done_r <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  cnt_j <= cnt_j + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign out_valid  = (st == ST_RUN);
   assign out_offset = r_r;
   assign out_done   = done_r;
endmodule

// File: rtl/qpp_addr_chk.sv
module qpp_addr_chk #(
   parameter int P_MAX = 8,
   parameter int AW    = 13,
   localparam int QW   = $clog2(P_MAX),
   localparam int PW   = $clog2(P_MAX + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [PW-1:0]       cfg_par,
   input logic                busy,
   input logic                out_valid,
   input logic [AW-1:0]       out_offset,
   input logic [P_MAX*QW-1:0] out_blk,
   input logic                out_done
);
   logic [PW-1:0] par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               par_q <= '0;
      else if (start && !busy)  par_q <= cfg_par;
   end

   p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (!out_valid && $past(out_valid)));

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   p_first_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_offset == '0));

   p_busy_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> !busy);

   p_run_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && start) |=> (out_valid || out_done));

   for (genvar p = 0; p < P_MAX; p++) begin : g_chk
      p_blk_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && (PW'(p) < par_q)) |->
            ({1'b0, out_blk[p*QW +: QW]} < {1'b0, par_q}));
      p_idle_lane_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && (PW'(p) >= par_q)) |-> (out_blk[p*QW +: QW] == '0));
   end
endmodule

bind qpp_par_addr_gen qpp_addr_chk #(.P_MAX(P_MAX), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cfg_par(cfg_par),
   .busy(busy), .out_valid(out_valid), .out_offset(out_offset),
   .out_blk(out_blk), .out_done(out_done)
);

// File: tb/tb_qpp_par_addr_gen.sv
`timescale 1ns/1ps
module tb_qpp_par_addr_gen;
   localparam int P_MAX = 8;
   localparam int AW    = 13;
   localparam int QW    = $clog2(P_MAX);
   localparam int PW    = $clog2(P_MAX + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [AW-1:0]       cfg_len = '0;
   logic [AW-1:0]       cfg_f1 = '0;
   logic [AW-1:0]       cfg_f2 = '0;
   logic [PW-1:0]       cfg_par = '0;
   logic                busy;
   logic                out_valid;
   logic [AW-1:0]       out_offset;
   logic [P_MAX*QW-1:0] out_blk;
   logic                out_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   qpp_par_addr_gen #(.P_MAX(P_MAX), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
      .cfg_f1(cfg_f1), .cfg_f2(cfg_f2), .cfg_par(cfg_par), .busy(busy),
      .out_valid(out_valid), .out_offset(out_offset), .out_blk(out_blk),
      .out_done(out_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint qpp_f(input longint k, input longint f1,
                                    input longint f2, input longint i);
      return (f1 * i + f2 * i * i) % k;
   endfunction

   task automatic run_case(input int k, input int f1, input int f2, input int p,
                           input bit perm, input bit poke, input string tag);
      int m = k / p;
      int guard = 0;
      @(negedge clk);
      cfg_len = AW'(k); cfg_f1 = AW'(f1); cfg_f2 = AW'(f2); cfg_par = PW'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9", {tag, " busy after start"}, busy, 1);
      while (!out_valid && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(out_valid, "R2", {tag, " run begins"}, out_valid, 1);
      for (int j = 0; j < m; j++) begin
         bit [P_MAX-1:0] seen = '0;
         chk(out_valid && busy && !out_done, "R2", {tag, " valid window"},
             {out_valid, busy, out_done}, 3'b110);
         for (int ln = 0; ln < P_MAX; ln++) begin
            int blk = int'(out_blk[ln*QW +: QW]);
            if (ln < p) begin
               longint e = qpp_f(k, f1, f2, longint'(ln * m + j));
               chk(blk == e / m, "R3", {tag, " segment index"}, blk, e / m);
               chk(out_offset == AW'(e % m), "R4", {tag, " shared offset"},
                   out_offset, e % m);
               seen[blk] = 1'b1;
            end else begin
               chk(blk == 0, "R5", {tag, " idle lane"}, blk, 0);
            end
         end
         if (perm) chk($countones(seen) == p, "R7", {tag, " distinct segments"},
                       $countones(seen), p);
         if (poke && j == m / 2) begin
            // R8: second start and changed configuration mid run
            start = 1'b1;
            cfg_len = AW'(k + 1); cfg_f1 = AW'(1); cfg_f2 = '0;
            cfg_par = PW'(1);
         end
         @(negedge clk);
         start = 1'b0;
      end
      chk(out_done && !out_valid, "R2", {tag, " done pulse"},
          {out_done, out_valid}, 2'b10);
      chk(!busy, "R9", {tag, " idle at done"}, busy, 0);
      @(negedge clk);
      chk(!out_done && !out_valid, "R2", {tag, " done ends"},
          {out_done, out_valid}, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk(!out_valid && !out_done && !busy && out_offset == 0 && out_blk == 0,
          "R1", "outputs in reset", {out_valid, out_done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !out_done && !busy && out_blk == 0,
          "R1", "outputs after reset", {out_valid, out_done, busy}, 0);

      run_case(40, 3, 10, 5, 1'b1, 1'b0, "k40p5");
      run_case(40, 3, 10, 8, 1'b1, 1'b0, "k40p8");
      run_case(48, 7, 12, 6, 1'b1, 1'b0, "R6 k48p6");
      run_case(48, 7, 12, 3, 1'b1, 1'b0, "R6 k48p3");
      run_case(120, 103, 90, 5, 1'b1, 1'b0, "R6 k120p5");
      run_case(240, 29, 60, 8, 1'b1, 1'b1, "R8 k240p8");
      run_case(512, 31, 64, 1, 1'b1, 1'b0, "R6 p1");
      run_case(8, 5, 3, 8, 1'b0, 1'b0, "R6 m1");
      run_case(6144, 263, 480, 6, 1'b1, 1'b0, "R10 k6144p6");
      run_case(120, 103, 90, 7 - 2, 1'b1, 1'b1, "R8 k120 poke");

      void'($urandom(32'd4242));
      for (int n = 0; n < 24; n++) begin
         int p  = 1 + int'($urandom % P_MAX);
         int m  = 1 + int'($urandom % 40);
         int k  = p * m;
         int f1 = int'($urandom % k);
         int f2 = int'($urandom % k);
         run_case(k, f1, f2, p, 1'b0, 1'b0, "R3 R6 random");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule